// File: doc/BRIEF.md
# Seconds Counter with Four Alarms

This block is a real-time clock peripheral on a simple word-addressed register port. It keeps a seconds count that software can load at any time. While the run bit is set, the count advances by one on each tick taken from one of two tick-enable inputs: a slow tick derived from a 32 kHz source or a fast tick derived from a 24 MHz source. The tick enables arrive already synchronised to `clk`, each high for one cycle per second.

Four alarm comparators watch the count. Each one has its own enable, its own interrupt mask and its own sticky fired flag, and software clears that flag by writing a one. The unmasked fired flags are ORed into a single interrupt line.

A drift-correction stage can adjust every N-th tick, where N is set in software. In drop mode that tick is swallowed. In insert mode that tick advances the count by two.

Top module: `rtc_quad_alarm`

## Requirements
- R1: After reset the control word (0x00), the live count (0x34), the status word (0x30) and `irq` all read 0. The interrupt mask resets to 0xF, so every alarm is blocked.
- R2: While control bit 12 (run) is 0, the count does not change, whatever the tick inputs do.
- R3: Control bit 8 chooses the tick source. 0 uses `slow_tick` and 1 uses `fast_tick`. The tick input that is not chosen has no effect on the count.
- R4: A write to 0x04 places the write data in the count on the next clock edge. This write wins over a tick in the same cycle, so that tick is lost. Reads of 0x04 and 0x34 return the live count.
- R5: Alarm i has its compare value at 0x08 + 4*i, and the register reads back. When an advance of the count lands exactly on that value, status bit i (0x30, bits 3:0) sets on the same edge and stays set.
- R6: Control bits 3:0 enable alarms 0 to 3. A disabled alarm never sets its status bit. Status bits 7:4 show the current alarm enables.
- R7: `irq` is high exactly when some alarm has its status bit set and its bit in the mask register (0x20, bits 3:0) is 0. A mask bit of 1 blocks that alarm.
- R8: Writing 1 to bit i of 0x24 clears status bit i. Writing 0 leaves it unchanged. The clear register always reads 0. If an alarm fires in the same cycle as its clear, the status bit stays set.
- R9: Register 0x18 holds the period N in bits 15:0 and the mode in bits 17:16. In drop mode (1), with N > 0, every N-th accepted tick does not advance the count. Counting starts from the last write to 0x18.
- R10: In insert mode (2), with N > 0, every N-th accepted tick advances the count by 2. Mode 0, mode 3 and N = 0 give a plain advance of one per tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per second from the slow source |
| fast_tick | input | 1 | One-cycle pulse per second from the fast source |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined alarm interrupt |

## Verification
The hardest case to create from the ports is an alarm firing in the very cycle that software writes its clear bit. The bench drives the chosen tick and the clear write on the same falling edge, with the count set one below the compare value. It then expects the fired bit to remain set.

The bench uses the same same-edge technique for a count load that coincides with a tick. It brings out the drop and insert patterns by running several full adjustment periods and comparing the final count with one computed by hand.

// File: rtl/rtc_pkg.sv
// Package: shared register word indexes and the drift-adjust mode type.
// Assumes a byte-addressed port whose registers are 32-bit words.
package rtc_pkg;
    localparam int unsigned W_CTRL   = 0;
    localparam int unsigned W_LOAD   = 1;
    localparam int unsigned W_ALARM0 = 2;
    localparam int unsigned W_ADJ    = 6;
    localparam int unsigned W_MASK   = 8;
    localparam int unsigned W_CLR    = 9;
    localparam int unsigned W_STATUS = 12;
    localparam int unsigned W_COUNT  = 13;

    localparam int unsigned CTRL_RUN_BIT = 12;
    localparam int unsigned CTRL_SEL_BIT = 8;
    localparam int unsigned ADJ_MODE_LSB = 16;

    typedef enum logic [1:0] {
        ADJ_OFF   = 2'd0,
        ADJ_SKIP  = 2'd1,
        ADJ_EXTRA = 2'd2,
        ADJ_RSVD  = 2'd3
    } adj_mode_t;
endpackage

// File: rtl/rtc_tick_adjust.sv
// Tick source select and drift correction.
// Produces the count step for this cycle: 0, 1 or 2.
// Assumes the tick inputs are one-cycle pulses synchronous to clk.
module rtc_tick_adjust #(
    parameter int unsigned PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                sel_fast,
    input  logic                slow_tick,
    input  logic                fast_tick,
    input  rtc_pkg::adj_mode_t  mode,
    input  logic [PERIOD_W-1:0] period,
    input  logic                restart,
    output logic [1:0]          step
);
    import rtc_pkg::*;

    logic [PERIOD_W-1:0] pcnt;
    logic                tick;
    logic                active;
    logic                hit;

    // Select the tick, then decide whether this tick is the adjusted one.
    always_comb begin
        tick   = run & (sel_fast ? fast_tick : slow_tick);
        active = ((mode == ADJ_SKIP) || (mode == ADJ_EXTRA)) && (period != '0);
        hit    = active && (pcnt == period - PERIOD_W'(1));
        if (!tick)
            step = 2'd0;
        else if (hit)
            step = (mode == ADJ_SKIP) ? 2'd0 : 2'd2;
        else
            step = 2'd1;
    end

    // Count the accepted ticks within the current adjustment period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !active)
            pcnt <= '0;
        else if (tick)
            pcnt <= hit ? '0 : pcnt + PERIOD_W'(1);
    end
endmodule

// File: rtl/rtc_seconds_counter.sv
// Seconds register.
// A load takes priority over an advance in the same cycle.
// It exposes the value the count is about to take, plus a flag for a true advance.
module rtc_seconds_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [1:0]       step,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] next_val,
    output logic             advance
);
    // Work out the advanced value and whether it is taken this cycle.
    always_comb begin
        next_val = count + CNT_W'(step);
        advance  = !load_en && (step != 2'd0);
    end

    // Hold, load or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load_en)
            count <= load_val;
        else if (advance)
            count <= next_val;
    end
endmodule

// File: rtl/rtc_alarm_bank.sv
// Alarm comparators with sticky fired flags.
// An alarm fires only when an advance lands exactly on its compare value.
// A fire wins over a clear in the same cycle.
module rtc_alarm_bank #(
    parameter int unsigned N_ALARM = 4,
    parameter int unsigned CNT_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_ALARM-1:0][CNT_W-1:0] cmp,
    input  logic [N_ALARM-1:0]            enable,
    input  logic                          advance,
    input  logic [CNT_W-1:0]              next_val,
    input  logic [N_ALARM-1:0]            clr,
    output logic [N_ALARM-1:0]            fired
);
    for (genvar i = 0; i < N_ALARM; i++) begin : g_alarm
        logic match;

        // Detect an enabled alarm being reached by this advance.
        always_comb match = advance && enable[i] && (next_val == cmp[i]);

        // Set on a match, otherwise clear on request.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fired[i] <= 1'b0;
            else if (match)
                fired[i] <= 1'b1;
            else if (clr[i])
                fired[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_quad_alarm.sv
// Top level: register port, control and mask state, and alarm compare registers.
// It wires the tick-adjust stage, the seconds counter and the alarm bank.
// Assumes N_ALARM <= 4 so that the alarm words stay below the adjust word,
// CNT_W <= DATA_W, and PERIOD_W <= 16.
module rtc_quad_alarm #(
    parameter int unsigned N_ALARM  = 4,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned PERIOD_W = 16,
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    import rtc_pkg::*;

    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0]             widx;
    logic                          unused_addr_lo;
    logic                          run_q;
    logic                          sel_q;
    logic [N_ALARM-1:0]            alm_en;
    logic [N_ALARM-1:0]            mask_q;
    logic [N_ALARM-1:0][CNT_W-1:0] alarm_q;
    adj_mode_t                     adj_mode;
    logic [PERIOD_W-1:0]           adj_period;
    logic                          load_we;
    logic                          adj_we;
    logic [N_ALARM-1:0]            clr_pulse;
    logic [1:0]                    step;
    logic [CNT_W-1:0]              count;
    logic [CNT_W-1:0]              next_val;
    logic                          advance;
    logic [N_ALARM-1:0]            fired;

    // Decode the word index and the write strobes.
    always_comb begin
        widx           = bus_addr[ADDR_W-1:2];
        unused_addr_lo = ^bus_addr[1:0];
        load_we        = bus_wen && (widx == WIDX_W'(W_LOAD));
        adj_we         = bus_wen && (widx == WIDX_W'(W_ADJ));
        clr_pulse      = (bus_wen && (widx == WIDX_W'(W_CLR))) ? bus_wdata[N_ALARM-1:0] : '0;
    end

    // Control, mask and adjust registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            sel_q      <= 1'b0;
            alm_en     <= '0;
            mask_q     <= '1;
            adj_mode   <= ADJ_OFF;
            adj_period <= '0;
        end else if (bus_wen) begin
            if (widx == WIDX_W'(W_CTRL)) begin
                run_q  <= bus_wdata[CTRL_RUN_BIT];
                sel_q  <= bus_wdata[CTRL_SEL_BIT];
                alm_en <= bus_wdata[N_ALARM-1:0];
            end
            if (widx == WIDX_W'(W_MASK))
                mask_q <= bus_wdata[N_ALARM-1:0];
            if (adj_we) begin
                adj_mode   <= adj_mode_t'(bus_wdata[ADJ_MODE_LSB +: 2]);
                adj_period <= bus_wdata[PERIOD_W-1:0];
            end
        end
    end

    // One compare register per alarm.
    for (genvar i = 0; i < N_ALARM; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n)
                alarm_q[i] <= '0;
            else if (bus_wen && (widx == WIDX_W'(W_ALARM0 + i)))
                alarm_q[i] <= bus_wdata[CNT_W-1:0];
        end
    end

    rtc_tick_adjust #(.PERIOD_W(PERIOD_W)) u_adjust (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .sel_fast  (sel_q),
        .slow_tick (slow_tick),
        .fast_tick (fast_tick),
        .mode      (adj_mode),
        .period    (adj_period),
        .restart   (adj_we),
        .step      (step)
    );

    rtc_seconds_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_we),
        .load_val (bus_wdata[CNT_W-1:0]),
        .step     (step),
        .count    (count),
        .next_val (next_val),
        .advance  (advance)
    );

    rtc_alarm_bank #(.N_ALARM(N_ALARM), .CNT_W(CNT_W)) u_alarms (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp      (alarm_q),
        .enable   (alm_en),
        .advance  (advance),
        .next_val (next_val),
        .clr      (clr_pulse),
        .fired    (fired)
    );

    // Combine the unmasked fired flags into the interrupt line.
    always_comb irq = |(fired & ~mask_q);

    // Read multiplexer; unmapped words and the clear word read as zero.
    always_comb begin
        bus_rdata = '0;
        case (widx)
            WIDX_W'(W_CTRL): begin
                bus_rdata[CTRL_RUN_BIT]  = run_q;
                bus_rdata[CTRL_SEL_BIT]  = sel_q;
                bus_rdata[N_ALARM-1:0]   = alm_en;
            end
            WIDX_W'(W_LOAD), WIDX_W'(W_COUNT):
                bus_rdata[CNT_W-1:0] = count;
            WIDX_W'(W_ADJ): begin
                bus_rdata[PERIOD_W-1:0]       = adj_period;
                bus_rdata[ADJ_MODE_LSB +: 2]  = adj_mode;
            end
            WIDX_W'(W_MASK):
                bus_rdata[N_ALARM-1:0] = mask_q;
            WIDX_W'(W_STATUS):
                bus_rdata[2*N_ALARM-1:0] = {alm_en, fired};
            default: begin
                for (int i = 0; i < N_ALARM; i++)
                    if (widx == WIDX_W'(W_ALARM0 + i))
                        bus_rdata[CNT_W-1:0] = alarm_q[i];
            end
        endcase
    end
endmodule

// File: rtl/rtc_quad_alarm_chk.sv
// Checker for rtc_quad_alarm, attached with bind.
// It watches the count, the fired flags, the enables and the mask over time.
module rtc_quad_alarm_chk #(
    parameter int unsigned N_ALARM = 4,
    parameter int unsigned CNT_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run_q,
    input logic               load_we,
    input logic [CNT_W-1:0]   load_val,
    input logic [CNT_W-1:0]   count,
    input logic [N_ALARM-1:0] fired,
    input logic [N_ALARM-1:0] alm_en,
    input logic [N_ALARM-1:0] mask_q,
    input logic [N_ALARM-1:0] clr_pulse,
    input logic               irq
);
    // R2: the count holds while stopped and not loaded
    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load_we) |=> (count == $past(count)));

    // R4: a load lands on the next edge
    a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (count == $past(load_val)));

    // R10: no step larger than two without a load
    a_r10_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !load_we |=> ((count - $past(count)) <= CNT_W'(2)));

    // R5: a fired flag stays set unless its clear bit is written
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse == '0) |=> ((fired & $past(fired)) == $past(fired)));

    // R6: a flag never rises for a disabled alarm
    a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_en == '0) |=> ((fired & ~$past(fired)) == '0));

    // R7: full mask keeps the line low, and a high line needs a fired flag
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq);
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (fired != '0));
endmodule

bind rtc_quad_alarm rtc_quad_alarm_chk #(.N_ALARM(N_ALARM), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_q     (run_q),
    .load_we   (load_we),
    .load_val  (bus_wdata[CNT_W-1:0]),
    .count     (count),
    .fired     (fired),
    .alm_en    (alm_en),
    .mask_q    (mask_q),
    .clr_pulse (clr_pulse),
    .irq       (irq)
);

// File: tb/rtc_quad_alarm_tb.sv
// Directed bench for rtc_quad_alarm: one task per scenario, each checking itself.
module rtc_quad_alarm_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        fast_tick = 1'b0;
    logic        bus_wen = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    rtc_quad_alarm u_dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Write one register; optionally pulse a tick input in the same cycle.
    task automatic wr(input logic [5:0] a, input logic [31:0] d,
                      input logic ts = 1'b0, input logic tf = 1'b0);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        slow_tick = ts; fast_tick = tf;
        @(negedge clk);
        bus_wen = 1'b0; slow_tick = 1'b0; fast_tick = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input bit fast, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (fast) fast_tick = 1'b1; else slow_tick = 1'b1;
            @(negedge clk);
            fast_tick = 1'b0; slow_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(6'h00, v); check("R1 ctrl", v, 32'h0);
        rd(6'h34, v); check("R1 count", v, 32'h0);
        rd(6'h30, v); check("R1 status", v, 32'h0);
        rd(6'h20, v); check("R1 mask", v, 32'hF);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_run_and_select();
        logic [31:0] v;
        wr(6'h04, 32'd100);
        ticks(0, 3);
        rd(6'h34, v); check("R2 stopped holds", v, 32'd100);
        wr(6'h00, 32'h1000);
        ticks(0, 3);
        rd(6'h34, v); check("R3 slow source", v, 32'd103);
        ticks(1, 2);
        rd(6'h34, v); check("R3 fast ignored", v, 32'd103);
        wr(6'h00, 32'h1100);
        ticks(1, 2);
        rd(6'h34, v); check("R3 fast source", v, 32'd105);
        ticks(0, 2);
        rd(6'h34, v); check("R3 slow ignored", v, 32'd105);
    endtask

    task automatic t_load_priority();
        logic [31:0] v;
        wr(6'h00, 32'h1000);
        wr(6'h04, 32'd500, 1'b1, 1'b0);
        rd(6'h34, v); check("R4 load beats tick", v, 32'd500);
        rd(6'h04, v); check("R4 load word reads count", v, 32'd500);
    endtask

    task automatic t_alarm_fire_mask_clear();
        logic [31:0] v;
        wr(6'h00, 32'h1001);
        wr(6'h08, 32'd505);
        wr(6'h20, 32'h0);
        wr(6'h04, 32'd503);
        rd(6'h08, v); check("R5 alarm readback", v, 32'd505);
        ticks(0, 1);
        rd(6'h30, v); check("R5 not yet", v, 32'h10);
        ticks(0, 1);
        rd(6'h30, v); check("R5 fired", v, 32'h11);
        check("R7 irq on", {31'b0, irq}, 32'h1);
        ticks(0, 1);
        rd(6'h30, v); check("R5 sticky", v, 32'h11);
        wr(6'h20, 32'h1);
        check("R7 masked", {31'b0, irq}, 32'h0);
        wr(6'h20, 32'h0);
        check("R7 unmasked", {31'b0, irq}, 32'h1);
        wr(6'h24, 32'h0);
        rd(6'h30, v); check("R8 zero write keeps", v, 32'h11);
        wr(6'h24, 32'h1);
        rd(6'h30, v); check("R8 cleared", v, 32'h10);
        check("R8 irq off", {31'b0, irq}, 32'h0);
        rd(6'h24, v); check("R8 clear reads zero", v, 32'h0);
    endtask

    task automatic t_disabled_alarm();
        logic [31:0] v;
        wr(6'h0C, 32'd508);
        ticks(0, 2);
        rd(6'h34, v); check("R6 count at compare", v, 32'd508);
        rd(6'h30, v); check("R6 disabled silent", v, 32'h10);
        check("R6 irq low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_clear_vs_fire();
        logic [31:0] v;
        wr(6'h10, 32'd600);
        wr(6'h00, 32'h1004);
        wr(6'h04, 32'd599);
        rd(6'h30, v); check("R6 enable mirror", v, 32'h40);
        wr(6'h24, 32'h4, 1'b1, 1'b0);
        rd(6'h30, v); check("R8 fire beats clear", v, 32'h44);
        wr(6'h24, 32'h4);
        rd(6'h30, v); check("R8 later clear", v, 32'h40);
    endtask

    task automatic t_drop();
        logic [31:0] v;
        wr(6'h00, 32'h1000);
        wr(6'h04, 32'd1000);
        wr(6'h18, (32'd1 << 16) | 32'd3);
        ticks(0, 6);
        rd(6'h34, v); check("R9 drop every third", v, 32'd1004);
    endtask

    task automatic t_insert();
        logic [31:0] v;
        wr(6'h18, (32'd2 << 16) | 32'd2);
        wr(6'h04, 32'd2000);
        ticks(0, 4);
        rd(6'h34, v); check("R10 insert every second", v, 32'd2006);
        wr(6'h18, (32'd3 << 16) | 32'd1);
        ticks(0, 3);
        rd(6'h34, v); check("R10 reserved mode plain", v, 32'd2009);
        wr(6'h18, (32'd1 << 16));
        ticks(0, 2);
        rd(6'h34, v); check("R10 zero period plain", v, 32'd2011);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_run_and_select();
        t_load_priority();
        t_alarm_fire_mask_clear();
        t_disabled_alarm();
        t_clear_vs_fire();
        t_drop();
        t_insert();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule